// File: doc/BRIEF.md
# Presence-Bit Directory Controller

This block is the home-node coherence controller for a range of memory blocks shared by a set of processors. For every block it records which processors hold a copy, as one presence bit per processor, and whether one of them holds it modified, as a single dirty bit. It takes read and write requests tagged with the requester ID. It sends recall or invalidate messages only to the processors its directory names, updates the backing memory with recalled data, and returns a data reply to the requester.

Messages leave on one output channel, one per cycle, with no backpressure. Each message carries a type, a destination, a block index and data. Acknowledgements come back on one input channel, tagged with their source. The backing memory is a small internal array. One request is in service at a time, and a new request waits at the input while the controller is busy.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every directory entry is clean with no presence bits set, memory block b holds the value b, `req_ready_o` is 1 and no message is sent.
- R2: A read of a clean block sends no message other than one data reply (type 0) to the requester, carrying the memory contents. The requester's presence bit is then set.
- R3: A read of a block held dirty by another processor sends one recall-to-shared message (type 2) to that owner. The owner's acknowledgement data is written to memory and returned to the requester. The block becomes clean, with both owner and requester present.
- R4: A write to a clean block sends one invalidate message (type 1) to each present processor other than the requester, lowest ID first. After the reply, only the requester is present and the block is dirty.
- R5: A write to a block held dirty by another processor sends one recall-to-invalid message (type 3) to that owner. The acknowledgement data is written to memory and returned to the requester. Only the requester is then present, and the block stays dirty.
- R6: The data reply is held back until every processor that was sent a recall or invalidate has acknowledged. An acknowledgement from a processor that was not sent one is ignored.
- R7: `req_ready_o` falls in the cycle after a request is accepted and rises again in the cycle after its data reply. While it is low, a presented request is not taken.
- R8: A read or write by the processor recorded as the dirty owner gets a data reply with the memory copy, sends no other message, and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken |
| req_write_i | input | 1 | 1 = write (exclusive) request, 0 = read |
| req_src_i | input | ID_W | Requesting processor |
| req_blk_i | input | BLK_W | Requested block |
| msg_valid_o | output | 1 | Outgoing message present this cycle |
| msg_type_o | output | 2 | 0 data, 1 invalidate, 2 recall-to-shared, 3 recall-to-invalid |
| msg_dest_o | output | ID_W | Destination processor |
| msg_blk_o | output | BLK_W | Block the message concerns |
| msg_data_o | output | DATA_W | Data (valid for type 0) |
| ack_valid_i | input | 1 | Acknowledgement present |
| ack_src_i | input | ID_W | Acknowledging processor |
| ack_data_i | input | DATA_W | Line data returned on a recall acknowledgement |

## Verification
A table of fourteen requests walks one block through every directory transition: clean reads that build up sharers, a write that invalidates three sharers, a read and a write that each recall from a dirty owner, an upgrade by a processor that already shares the block, and requests from the owner itself. Each row compares the set of invalidation targets, the recall kind and destination, and the reply data. This tells a missing or stray presence bit apart from a wrong dirty flag and from a memory copy that was not updated. A second block runs in the same walk to show that the entries are kept apart. Directed tests then present a request while the controller is busy, send a stray acknowledgement and hold back one of two invalidation acknowledgements to check when the reply goes out, and reset in the middle of the run to show that the directory and the memory return to their reset contents.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    MSG_DATA    = 2'd0,
    MSG_INV     = 2'd1,
    MSG_RCL_SH  = 2'd2,
    MSG_RCL_INV = 2'd3
  } msg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_REPLY
  } st_e;
endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins: scan downward so the last match is the lowest
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BLK_W-1:0]    rd_idx_i,
  output logic [NUM_PROC-1:0] rd_pres_o,
  output logic                rd_dirty_o,
  input  logic                we_i,
  input  logic [BLK_W-1:0]    wr_idx_i,
  input  logic [NUM_PROC-1:0] wr_pres_i,
  input  logic                wr_dirty_i
);
  logic [NUM_PROC-1:0] pres_q  [NUM_BLK];
  logic                dirty_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (we_i && wr_idx_i == BLK_W'(b)) begin
        pres_q[b]  <= wr_pres_i;
        dirty_q[b] <= wr_dirty_i;
      end
    end
  end

  assign rd_pres_o  = pres_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
endmodule

// File: rtl/dir_mem.sv
module dir_mem #(
  parameter int NUM_BLK = 8,
  parameter int DATA_W  = 16,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [BLK_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[b] <= DATA_W'(b);
      else if (we_i && wr_idx_i == BLK_W'(b))   mem_q[b] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 8,
  parameter int DATA_W   = 16,
  localparam int ID_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              msg_valid_o,
  output msg_e              msg_type_o,
  output logic [ID_W-1:0]   msg_dest_o,
  output logic [BLK_W-1:0]  msg_blk_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              ack_valid_i,
  input  logic [ID_W-1:0]   ack_src_i,
  input  logic [DATA_W-1:0] ack_data_i
);
  st_e                 st_q;
  logic [ID_W-1:0]     src_q;
  logic [BLK_W-1:0]    blk_q;
  logic                wr_q, own_q, dirty_q;
  logic [NUM_PROC-1:0] pres_q, send_q, wait_q;
  msg_e                kind_q;

  logic [NUM_PROC-1:0] rd_pres, grant, self_req, self_q, send_nxt, targets;
  logic                rd_dirty, accept, ack_hit, dir_we, mem_we, owner_is_req;
  logic [ID_W-1:0]     pick_idx;
  logic [DATA_W-1:0]   mem_rd;
  logic [NUM_PROC-1:0] new_pres;
  logic                new_dirty;
  msg_e                kind_d;

  dir_store #(.NUM_PROC(NUM_PROC), .NUM_BLK(NUM_BLK)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i  (req_blk_i),
    .rd_pres_o (rd_pres),
    .rd_dirty_o(rd_dirty),
    .we_i      (dir_we),
    .wr_idx_i  (blk_q),
    .wr_pres_i (new_pres),
    .wr_dirty_i(new_dirty)
  );

  dir_mem #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .rd_idx_i (blk_q),
    .rd_data_o(mem_rd),
    .we_i     (mem_we),
    .wr_idx_i (blk_q),
    .wr_data_i(ack_data_i)
  );

  dir_pick #(.N(NUM_PROC)) u_pick (
    .mask_i (send_q),
    .grant_o(grant),
    .idx_o  (pick_idx)
  );

  assign req_ready_o  = (st_q == ST_IDLE);
  assign accept       = req_valid_i && req_ready_o;
  assign self_req     = NUM_PROC'(1) << req_src_i;
  assign self_q       = NUM_PROC'(1) << src_q;
  assign owner_is_req = rd_dirty && (rd_pres == self_req);

  // who must be contacted before the reply, and with what
  always_comb begin
    targets = '0;
    kind_d  = MSG_INV;
    if (owner_is_req) begin
      targets = '0;
    end else if (rd_dirty) begin
      targets = rd_pres;
      kind_d  = req_write_i ? MSG_RCL_INV : MSG_RCL_SH;
    end else if (req_write_i) begin
      targets = rd_pres & ~self_req;
    end
  end

  assign send_nxt = send_q & ~grant;
  assign ack_hit  = ack_valid_i && (st_q == ST_SEND || st_q == ST_WAIT) && wait_q[ack_src_i];
  assign mem_we   = ack_hit && (kind_q != MSG_INV);
  assign dir_we   = (st_q == ST_REPLY);

  always_comb begin
    if (wr_q) begin
      new_pres  = self_q;
      new_dirty = 1'b1;
    end else begin
      new_pres  = pres_q | self_q;
      new_dirty = dirty_q && own_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      src_q   <= '0;
      blk_q   <= '0;
      wr_q    <= 1'b0;
      own_q   <= 1'b0;
      dirty_q <= 1'b0;
      pres_q  <= '0;
      send_q  <= '0;
      wait_q  <= '0;
      kind_q  <= MSG_INV;
    end else begin
      if (ack_hit) wait_q[ack_src_i] <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_SEND;
          src_q   <= req_src_i;
          blk_q   <= req_blk_i;
          wr_q    <= req_write_i;
          own_q   <= owner_is_req;
          dirty_q <= rd_dirty;
          pres_q  <= rd_pres;
          send_q  <= targets;
          wait_q  <= targets;
          kind_q  <= kind_d;
        end
        ST_SEND: begin
          send_q <= send_nxt;
          if (send_nxt == '0) st_q <= ST_WAIT;
        end
        ST_WAIT:  if (wait_q == '0) st_q <= ST_REPLY;
        ST_REPLY: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    msg_valid_o = 1'b0;
    msg_type_o  = MSG_DATA;
    msg_dest_o  = src_q;
    msg_blk_o   = blk_q;
    msg_data_o  = mem_rd;
    if (st_q == ST_SEND && send_q != '0) begin
      msg_valid_o = 1'b1;
      msg_type_o  = kind_q;
      msg_dest_o  = pick_idx;
    end else if (st_q == ST_REPLY) begin
      msg_valid_o = 1'b1;
    end
  end
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk
  import dir_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int ID_W     = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                msg_valid_o,
  input msg_e                msg_type_o,
  input logic [ID_W-1:0]     msg_dest_o,
  input logic [ID_W-1:0]     src_q,
  input logic [NUM_PROC-1:0] wait_q,
  input logic [NUM_PROC-1:0] pres_q,
  input logic                dirty_q
);
  p_accept_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_reply_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_DATA |=> req_ready_o);

  p_reply_after_acks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_DATA |-> wait_q == '0);

  p_reply_to_requester_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_DATA |-> msg_dest_o == src_q);

  p_inv_not_self_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_INV |-> msg_dest_o != src_q && pres_q[msg_dest_o]);

  p_recall_to_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_type_o == MSG_RCL_SH || msg_type_o == MSG_RCL_INV)
      |-> dirty_q && pres_q[msg_dest_o]);

  p_single_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && dirty_q |-> $onehot(pres_q));
endmodule

bind dir_ctrl dir_ctrl_chk #(.NUM_PROC(NUM_PROC), .ID_W(ID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .msg_valid_o(msg_valid_o),
  .msg_type_o (msg_type_o),
  .msg_dest_o (msg_dest_o),
  .src_q      (src_q),
  .wait_q     (wait_q),
  .pres_q     (pres_q),
  .dirty_q    (dirty_q)
);

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
  import dir_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ack_valid = 1'b0;
  logic [1:0] req_src = '0, ack_src = '0;
  logic [2:0] req_blk = '0;
  logic [DW-1:0] ack_data = '0;
  logic req_ready, msg_valid;
  msg_e msg_type;
  logic [1:0] msg_dest;
  logic [2:0] msg_blk;
  logic [DW-1:0] msg_data;

  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_ctrl #(.NUM_PROC(NP), .NUM_BLK(NB), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_src_i(req_src), .req_blk_i(req_blk),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dest_o(msg_dest),
    .msg_blk_o(msg_blk), .msg_data_o(msg_data),
    .ack_valid_i(ack_valid), .ack_src_i(ack_src), .ack_data_i(ack_data)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  src;
    logic [2:0]  blk;
    logic [3:0]  inv;   // expected invalidate targets
    logic [1:0]  rk;    // expected recall type, 0 = none
    logic [1:0]  rd;    // expected recall destination
    logic [15:0] data;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 3'd0, 4'h0, 2'd0, 2'd0, 16'h0000},
    '{1'b0, 2'd1, 3'd0, 4'h0, 2'd0, 2'd0, 16'h0000},
    '{1'b0, 2'd2, 3'd0, 4'h0, 2'd0, 2'd0, 16'h0000},
    '{1'b1, 2'd3, 3'd0, 4'h7, 2'd0, 2'd0, 16'h0000},
    '{1'b0, 2'd1, 3'd0, 4'h0, 2'd2, 2'd3, 16'hC030},
    '{1'b1, 2'd1, 3'd0, 4'h8, 2'd0, 2'd0, 16'hC030},
    '{1'b1, 2'd2, 3'd0, 4'h0, 2'd3, 2'd1, 16'hC010},
    '{1'b0, 2'd0, 3'd1, 4'h0, 2'd0, 2'd0, 16'h0001},
    '{1'b1, 2'd0, 3'd1, 4'h0, 2'd0, 2'd0, 16'h0001},
    '{1'b0, 2'd3, 3'd0, 4'h0, 2'd2, 2'd2, 16'hC020},
    '{1'b1, 2'd0, 3'd0, 4'hC, 2'd0, 2'd0, 16'hC020},
    '{1'b1, 2'd0, 3'd0, 4'h0, 2'd0, 2'd0, 16'hC020},
    '{1'b0, 2'd1, 3'd1, 4'h0, 2'd2, 2'd0, 16'hC001},
    '{1'b0, 2'd0, 3'd1, 4'h0, 2'd0, 2'd0, 16'hC001}
  };
  string vtag [NV] = '{"R2", "R2", "R2", "R4", "R3", "R4", "R5",
                       "R2", "R4", "R3", "R4", "R8", "R3", "R2"};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] owner_val(input int p, input int b);
    return DW'(32'hC000 | (p << 4) | b);
  endfunction

  task automatic send_req(input logic wr, input logic [1:0] src, input logic [2:0] blk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_src = src; req_blk = blk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // processors answer each recall/invalidate, one ack per idle cycle
  task automatic serve(input logic [2:0] blk, output logic [3:0] inv, output int rk,
                       output int rd, output logic [DW-1:0] data, output bit got);
    logic [3:0] pend;
    inv = '0; rk = 0; rd = 0; data = '0; got = 1'b0; pend = '0;
    for (int c = 0; c < 60 && !got; c++) begin
      if (c > 0) @(negedge clk);
      ack_valid = 1'b0;
      if (msg_valid) begin
        if (msg_type == MSG_DATA) begin
          data = msg_data; got = 1'b1;
        end else begin
          if (msg_type == MSG_INV) inv[msg_dest] = 1'b1;
          else begin rk = int'(msg_type); rd = int'(msg_dest); end
          pend[msg_dest] = 1'b1;
        end
      end else if (pend != '0) begin
        for (int p = NP - 1; p >= 0; p--) if (pend[p]) ack_src = 2'(p);
        pend[ack_src] = 1'b0;
        ack_valid = 1'b1;
        ack_data  = owner_val(int'(ack_src), int'(blk));
      end
    end
    if (!got) @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    logic [3:0] inv; int rk, rd; logic [DW-1:0] data; bit got;
    send_req(v.wr, v.src, v.blk);
    serve(v.blk, inv, rk, rd, data, got);
    check(got, tag, "reply seen", int'(got), 1);
    check(inv == v.inv, tag, "invalidate set", int'(inv), int'(v.inv));
    check(rk == int'(v.rk), tag, "recall type", rk, int'(v.rk));
    if (v.rk != 0) check(rd == int'(v.rd), tag, "recall dest", rd, int'(v.rd));
    check(data == v.data, tag, "reply data", int'(data), int'(v.data));
  endtask

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] inv; int n; logic [DW-1:0] d; bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R1", "no message after reset", int'(msg_valid), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], vtag[i]);

    // R6/R7: two sharers of block 2, then a write held on the acks
    run_vec('{1'b0, 2'd0, 3'd2, 4'h0, 2'd0, 2'd0, 16'h0002}, "R2");
    run_vec('{1'b0, 2'd1, 3'd2, 4'h0, 2'd0, 2'd0, 16'h0002}, "R2");
    send_req(1'b1, 2'd2, 3'd2);
    inv = '0; n = 0;
    for (int c = 0; c < 4; c++) begin
      if (msg_valid && msg_type == MSG_INV) begin
        inv[msg_dest] = 1'b1;
        if (n == 0) check(msg_dest == 2'd0, "R4", "lowest ID first", int'(msg_dest), 0);
        n++;
      end
      @(negedge clk);
    end
    check(inv == 4'h3, "R4", "invalidate set blk2", int'(inv), 3);
    req_valid = 1'b1; req_write = 1'b0; req_src = 2'd3; req_blk = 3'd3;
    @(negedge clk);
    check(req_ready == 1'b0, "R7", "busy while acks pending", int'(req_ready), 0);
    req_valid = 1'b0;
    ack_valid = 1'b1; ack_src = 2'd3; ack_data = 16'hDEAD;  // stray ack
    @(negedge clk);
    ack_src = 2'd0;
    @(negedge clk);
    ack_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(msg_valid == 1'b0, "R6", "no reply with one ack missing", int'(msg_valid), 0);
    ack_valid = 1'b1; ack_src = 2'd1;
    @(negedge clk);
    ack_valid = 1'b0;
    got = 1'b0; d = '0;
    for (int c = 0; c < 6 && !got; c++) begin
      if (msg_valid && msg_type == MSG_DATA) begin got = 1'b1; d = msg_data; end
      else @(negedge clk);
    end
    check(got, "R6", "reply after last ack", int'(got), 1);
    check(d == 16'h0002, "R6", "reply data blk2", int'(d), 2);
    check(req_ready == 1'b0, "R7", "busy during reply", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready == 1'b1, "R7", "ready after reply", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R7", "queued request not taken", int'(msg_valid), 0);

    // R1: reset mid-run restores directory and memory
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_vec('{1'b1, 2'd1, 3'd0, 4'h0, 2'd0, 2'd0, 16'h0000}, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule